// File: doc/BRIEF.md
# Double-Buffered Block Transfer Controller

This block sits between a host port and a peripheral port and steers block transfers through a pair of RAM buffers. One buffer is filled by the producing side while the other is emptied by the consuming side, and the two change roles at block boundaries. The buffers, the DMA engines and the converters are outside the block. The block only tracks which buffer each side owns, whether each buffer holds a complete block, and the length each port's engine should be armed with.

After any reset the controller waits for a header of four words written on the host data port. The header sets the mode, the block length, the pacing rate and the number of scanned channels. A header with an illegal word is refused. Once a legal header has been taken, the controller runs until the host resets it again, which it may do at any time. Two indicator outputs show its state. Green blinks while a header is awaited and stays lit while the controller is running. Red lights when the consuming side has finished a block and no filled buffer is ready to take its place.

Top module: `dbuf_xfer_ctl`

## Requirements
- R1: After a hardware reset (`rst_n` low) every output is 0: `run`, `cfg_err`, `mode_o`, `blk_len_o`, `rate_o`, `chan_o`, `buf_sel`, both armed lengths, `out_of_data`, and both LEDs are unlit.
- R2: While not running, each `host_wr_vld` cycle takes one header word. The words come in this order: mode, block length, pacing rate, channel count. In the cycle after the fourth legal word, `run` is 1 and the header values appear on `mode_o`, `blk_len_o`, `rate_o` and `chan_o`. Before that, these outputs keep their values.
- R3: The legal ranges are: mode word at most 7, with the mode in bits [2:0]; block length from 1 to MAX_BLK (4000); channel count exactly 1 for modes 0 and 1, and 1 to MAX_CHAN (16) for every other mode. An illegal word sets `cfg_err`, restarts the header at the mode word and keeps `run` at 0. `cfg_err` clears when a complete legal header is taken.
- R4: While running, host writes have no effect on the configuration outputs.
- R5: Modes 0 and 2 are input modes: the peripheral fills and the host drains. Modes 1, 3, 5, 6 and 7 are output modes: the host fills and the peripheral drains. `host_blk_done` and `per_blk_done` mark a finished block on the matching side.
- R6: `buf_sel` names the buffer that the filling side owns; the draining side owns the other one. Both buffers start empty with `buf_sel` = 0. A fill event marks the fill buffer full. A drain event marks the drain buffer empty. When, after these updates, the fill buffer is full and the drain buffer is empty, `buf_sel` toggles in that same clock edge. A fill event on a buffer that is already full has no effect.
- R7: While running, a port's armed length equals `blk_len_o` when that port fills an empty buffer or drains a full one; otherwise it is 0. Both armed lengths are 0 while not running.
- R8: A drain event that does not cause a swap sets `out_of_data` and lights red. The next swap clears it.
- R9: While not running, green toggles once every BLINK_DIV cycles, starting unlit after each reset. While running, green is steadily lit.
- R10: A `soft_rst` pulse, accepted in any state, returns every output to its R1 value in the next cycle.
- R11: In echo mode (4) the peripheral both fills and drains. Each `per_blk_done` completes one block in and one block out, so the buffers swap on every such event. `host_len` stays 0 and `host_blk_done` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous host reset, active high |
| host_wr_vld | input | 1 | Host word strobe |
| host_wr_data | input | DATA_W | Host word (header words while not running) |
| host_blk_done | input | 1 | Host-side engine finished a block |
| per_blk_done | input | 1 | Peripheral-side engine finished a block |
| run | output | 1 | Configured and transferring |
| cfg_err | output | 1 | Last header word was illegal |
| mode_o | output | 3 | Configured mode |
| blk_len_o | output | LEN_W | Configured block length |
| rate_o | output | DATA_W | Configured pacing rate word |
| chan_o | output | CHAN_W | Configured channel count |
| buf_sel | output | 1 | Buffer currently owned by the filling side |
| host_len | output | LEN_W | Length to arm on the host engine, 0 = idle |
| per_len | output | LEN_W | Length to arm on the peripheral engine, 0 = idle |
| out_of_data | output | 1 | Drain side starved |
| led_green | output | 1 | Ready / configured indicator |
| led_red | output | 1 | Out-of-data indicator |

## Verification
The assertions check these properties on every cycle:
- the error flag never coexists with `run`;
- the configuration stays frozen while running;
- a buffer swap only follows a block event or a soft reset;
- an armed length is either 0 or the configured length;
- green is steady while running;
- echo mode never arms the host;
- a soft reset empties the state.

Some behaviours only the bench scenarios can show: the header word order and its range boundaries (4000 against 4001, one channel against two in the fast modes), the exact blink period, starvation and its recovery, simultaneous fill and drain events, a fill ignored while both buffers are full, and the change of direction between the input, output and echo modes.

// File: rtl/dbuf_xfer_pkg.sv
package dbuf_xfer_pkg;

   typedef enum logic [2:0] {
      MD_HS_IN   = 3'd0,
      MD_HS_OUT  = 3'd1,
      MD_LS_IN   = 3'd2,
      MD_LS_OUT  = 3'd3,
      MD_ECHO    = 3'd4,
      MD_PRINT   = 3'd5,
      MD_RASTER  = 3'd6,
      MD_VECTOR  = 3'd7
   } xfer_mode_e;

   typedef enum logic [1:0] {
      ROLE_IN   = 2'd0,
      ROLE_OUT  = 2'd1,
      ROLE_ECHO = 2'd2
   } xfer_role_e;

   // R5 / R11: which side produces and which consumes
   function automatic xfer_role_e role_of(input xfer_mode_e m);
      case (m)
         MD_HS_IN, MD_LS_IN: role_of = ROLE_IN;
         MD_ECHO:            role_of = ROLE_ECHO;
         default:            role_of = ROLE_OUT;
      endcase
   endfunction

   function automatic logic is_fast(input xfer_mode_e m);
      return (m == MD_HS_IN) || (m == MD_HS_OUT);
   endfunction

endpackage

// File: rtl/dbuf_cfg_loader.sv
module dbuf_cfg_loader
   import dbuf_xfer_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int MAX_BLK  = 4000,
   parameter int MAX_CHAN = 16,
   parameter int LEN_W    = 12,
   parameter int CHAN_W   = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              wr_vld,
   input  logic [DATA_W-1:0] wr_data,
   output logic              run_q,
   output logic              err_q,
   output xfer_mode_e        mode_q,
   output logic [LEN_W-1:0]  len_q,
   output logic [DATA_W-1:0] rate_q,
   output logic [CHAN_W-1:0] chan_q
);

   typedef enum logic [1:0] {SL_MODE, SL_SIZE, SL_RATE, SL_CHAN} slot_e;

   slot_e             slot_q;
   xfer_mode_e        mode_t;
   logic [LEN_W-1:0]  len_t;
   logic [DATA_W-1:0] rate_t;
   logic              word_ok;
   logic              take;

   assign take = wr_vld && !run_q;

   // R3: range check of the word in the current slot
   always_comb begin
      case (slot_q)
         SL_MODE: word_ok = (wr_data <= DATA_W'(7));
         SL_SIZE: word_ok = (wr_data != '0) && (wr_data <= DATA_W'(MAX_BLK));
         SL_RATE: word_ok = 1'b1;
         default: word_ok = is_fast(mode_t) ? (wr_data == DATA_W'(1))
                          : ((wr_data != '0) && (wr_data <= DATA_W'(MAX_CHAN)));
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= SL_MODE;
         run_q  <= 1'b0;
         err_q  <= 1'b0;
         mode_t <= MD_HS_IN;
         len_t  <= '0;
         rate_t <= '0;
         mode_q <= MD_HS_IN;
         len_q  <= '0;
         rate_q <= '0;
         chan_q <= '0;
      end else if (soft_rst) begin
         slot_q <= SL_MODE;
         run_q  <= 1'b0;
         err_q  <= 1'b0;
         mode_t <= MD_HS_IN;
         len_t  <= '0;
         rate_t <= '0;
         mode_q <= MD_HS_IN;
         len_q  <= '0;
         rate_q <= '0;
         chan_q <= '0;
      end else if (take) begin
         if (!word_ok) begin
            err_q  <= 1'b1;
            slot_q <= SL_MODE;
         end else begin
            case (slot_q)
               SL_MODE: begin
                  mode_t <= xfer_mode_e'(wr_data[2:0]);
                  slot_q <= SL_SIZE;
               end
               SL_SIZE: begin
                  len_t  <= wr_data[LEN_W-1:0];
                  slot_q <= SL_RATE;
               end
               SL_RATE: begin
                  rate_t <= wr_data;
                  slot_q <= SL_CHAN;
               end
               default: begin
                  mode_q <= mode_t;
                  len_q  <= len_t;
                  rate_q <= rate_t;
                  chan_q <= wr_data[CHAN_W-1:0];
                  run_q  <= 1'b1;
                  err_q  <= 1'b0;
                  slot_q <= SL_MODE;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/dbuf_pingpong.sv
module dbuf_pingpong
   import dbuf_xfer_pkg::*;
#(
   parameter int LEN_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             run,
   input  xfer_role_e       role,
   input  logic             host_done,
   input  logic             per_done,
   input  logic [LEN_W-1:0] len,
   output logic             sel_q,
   output logic             ood_q,
   output logic [LEN_W-1:0] host_len,
   output logic [LEN_W-1:0] per_len
);

   logic [1:0] full_q;
   logic [1:0] full_n;
   logic       fill_ev;
   logic       drain_ev;
   logic       swap;
   logic       fill_arm;
   logic       drain_arm;

   // R5 / R11: map side events onto fill and drain
   always_comb begin
      case (role)
         ROLE_IN: begin
            fill_ev  = per_done;
            drain_ev = host_done;
         end
         ROLE_ECHO: begin
            fill_ev  = per_done;
            drain_ev = per_done;
         end
         default: begin
            fill_ev  = host_done;
            drain_ev = per_done;
         end
      endcase
   end

   // R6: flag update then swap test
   always_comb begin
      full_n = full_q;
      if (fill_ev)  full_n[sel_q]  = 1'b1;
      if (drain_ev) full_n[~sel_q] = 1'b0;
      swap = full_n[sel_q] && !full_n[~sel_q];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= '0;
         sel_q  <= 1'b0;
         ood_q  <= 1'b0;
      end else if (soft_rst || !run) begin
         full_q <= '0;
         sel_q  <= 1'b0;
         ood_q  <= 1'b0;
      end else begin
         full_q <= full_n;
         if (swap) begin
            sel_q <= ~sel_q;
            ood_q <= 1'b0;
         end else if (drain_ev) begin
            ood_q <= 1'b1;   // R8: starved
         end
      end
   end

   // R7: armed lengths
   assign fill_arm  = run && !full_q[sel_q];
   assign drain_arm = run &&  full_q[~sel_q];

   always_comb begin
      case (role)
         ROLE_IN: begin
            host_len = drain_arm ? len : '0;
            per_len  = fill_arm  ? len : '0;
         end
         ROLE_ECHO: begin
            host_len = '0;
            per_len  = run ? len : '0;
         end
         default: begin
            host_len = fill_arm  ? len : '0;
            per_len  = drain_arm ? len : '0;
         end
      endcase
   end

endmodule

// File: rtl/dbuf_status_led.sv
module dbuf_status_led #(
   parameter int BLINK_DIV   = 25_000_000,
   parameter int LED_ON_HIGH = 1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic run,
   input  logic ood,
   output logic led_green,
   output logic led_red
);

   localparam int CNT_W = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic             blink_q;
   logic             green_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         blink_q <= 1'b0;
      end else if (soft_rst || run) begin
         cnt_q   <= '0;
         blink_q <= 1'b0;
      end else if (cnt_q == CNT_W'(BLINK_DIV - 1)) begin
         cnt_q   <= '0;
         blink_q <= ~blink_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign green_raw = run | blink_q;

   generate
      if (LED_ON_HIGH != 0) begin : g_hi
         assign led_green = green_raw;
         assign led_red   = ood;
      end else begin : g_lo
         assign led_green = ~green_raw;
         assign led_red   = ~ood;
      end
   endgenerate

endmodule

// File: rtl/dbuf_xfer_ctl.sv
module dbuf_xfer_ctl
   import dbuf_xfer_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int MAX_BLK     = 4000,
   parameter int MAX_CHAN    = 16,
   parameter int BLINK_DIV   = 25_000_000,
   parameter int LED_ON_HIGH = 1,
   localparam int LEN_W      = $clog2(MAX_BLK + 1),
   localparam int CHAN_W     = $clog2(MAX_CHAN + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              host_wr_vld,
   input  logic [DATA_W-1:0] host_wr_data,
   input  logic              host_blk_done,
   input  logic              per_blk_done,
   output logic              run,
   output logic              cfg_err,
   output logic [2:0]        mode_o,
   output logic [LEN_W-1:0]  blk_len_o,
   output logic [DATA_W-1:0] rate_o,
   output logic [CHAN_W-1:0] chan_o,
   output logic              buf_sel,
   output logic [LEN_W-1:0]  host_len,
   output logic [LEN_W-1:0]  per_len,
   output logic              out_of_data,
   output logic              led_green,
   output logic              led_red
);

   generate
      if (MAX_BLK < 1 || LEN_W > DATA_W) begin : g_bad_blk
         $error("dbuf_xfer_ctl: MAX_BLK must be >= 1 and fit in DATA_W");
      end
      if (MAX_CHAN < 1 || CHAN_W > DATA_W) begin : g_bad_chan
         $error("dbuf_xfer_ctl: MAX_CHAN must be >= 1 and fit in DATA_W");
      end
      if (DATA_W < 3) begin : g_bad_data
         $error("dbuf_xfer_ctl: DATA_W must hold a mode word");
      end
      if (BLINK_DIV < 1) begin : g_bad_blink
         $error("dbuf_xfer_ctl: BLINK_DIV must be >= 1");
      end
   endgenerate

   xfer_mode_e mode_w;
   xfer_role_e role_w;

   dbuf_cfg_loader #(
      .DATA_W   (DATA_W),
      .MAX_BLK  (MAX_BLK),
      .MAX_CHAN (MAX_CHAN),
      .LEN_W    (LEN_W),
      .CHAN_W   (CHAN_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .wr_vld   (host_wr_vld),
      .wr_data  (host_wr_data),
      .run_q    (run),
      .err_q    (cfg_err),
      .mode_q   (mode_w),
      .len_q    (blk_len_o),
      .rate_q   (rate_o),
      .chan_q   (chan_o)
   );

   assign mode_o = mode_w;
   assign role_w = role_of(mode_w);

   dbuf_pingpong #(
      .LEN_W (LEN_W)
   ) u_pp (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .run       (run),
      .role      (role_w),
      .host_done (host_blk_done),
      .per_done  (per_blk_done),
      .len       (blk_len_o),
      .sel_q     (buf_sel),
      .ood_q     (out_of_data),
      .host_len  (host_len),
      .per_len   (per_len)
   );

   dbuf_status_led #(
      .BLINK_DIV   (BLINK_DIV),
      .LED_ON_HIGH (LED_ON_HIGH)
   ) u_led (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .run       (run),
      .ood       (out_of_data),
      .led_green (led_green),
      .led_red   (led_red)
   );

endmodule

// File: rtl/dbuf_xfer_chk.sv
module dbuf_xfer_chk #(
   parameter int LEN_W       = 12,
   parameter int MAX_BLK     = 4000,
   parameter int LED_ON_HIGH = 1
)(
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic             host_wr_vld,
   input logic             host_blk_done,
   input logic             per_blk_done,
   input logic             run,
   input logic             cfg_err,
   input logic [2:0]       mode_o,
   input logic [LEN_W-1:0] blk_len_o,
   input logic [LEN_W-1:0] host_len,
   input logic [LEN_W-1:0] per_len,
   input logic             buf_sel,
   input logic             out_of_data,
   input logic             led_green
);

   localparam logic ON = (LED_ON_HIGH != 0);

   a_r2_run_after_word: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> $past(host_wr_vld));

   a_r3_err_not_running: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !run);

   a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> ($stable(mode_o) && $stable(blk_len_o)));

   a_r6_swap_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_sel != $past(buf_sel)) |->
         ($past(host_blk_done) || $past(per_blk_done) || $past(soft_rst)));

   a_r7_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (host_len == '0 || host_len == blk_len_o) &&
      (per_len  == '0 || per_len  == blk_len_o) &&
      (blk_len_o <= LEN_W'(MAX_BLK)));

   a_r8_starve_only_running: assert property (@(posedge clk) disable iff (!rst_n)
      out_of_data |-> run);

   a_r9_green_steady: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (led_green == ON));

   a_r10_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $past(soft_rst) |-> (!run && !buf_sel && !out_of_data && !cfg_err));

   a_r11_echo_host_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode_o == 3'd4) |-> (host_len == '0));

endmodule

bind dbuf_xfer_ctl dbuf_xfer_chk #(
   .LEN_W       (LEN_W),
   .MAX_BLK     (MAX_BLK),
   .LED_ON_HIGH (LED_ON_HIGH)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .soft_rst      (soft_rst),
   .host_wr_vld   (host_wr_vld),
   .host_blk_done (host_blk_done),
   .per_blk_done  (per_blk_done),
   .run           (run),
   .cfg_err       (cfg_err),
   .mode_o        (mode_o),
   .blk_len_o     (blk_len_o),
   .host_len      (host_len),
   .per_len       (per_len),
   .buf_sel       (buf_sel),
   .out_of_data   (out_of_data),
   .led_green     (led_green)
);

// File: tb/sim_dbuf_xfer_ctl.sv
`timescale 1ns/1ps
module sim_dbuf_xfer_ctl;

   localparam int BD    = 4;
   localparam int MAXB  = 4000;
   localparam int MAXC  = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        host_wr_vld = 1'b0;
   logic [15:0] host_wr_data = '0;
   logic        host_blk_done = 1'b0;
   logic        per_blk_done = 1'b0;
   logic        run, cfg_err, buf_sel, out_of_data, led_green, led_red;
   logic [2:0]  mode_o;
   logic [11:0] blk_len_o, host_len, per_len;
   logic [15:0] rate_o;
   logic [4:0]  chan_o;

   always #2 clk = ~clk;

   dbuf_xfer_ctl #(.BLINK_DIV(BD)) u0 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .host_wr_vld(host_wr_vld), .host_wr_data(host_wr_data),
      .host_blk_done(host_blk_done), .per_blk_done(per_blk_done),
      .run(run), .cfg_err(cfg_err), .mode_o(mode_o), .blk_len_o(blk_len_o),
      .rate_o(rate_o), .chan_o(chan_o), .buf_sel(buf_sel),
      .host_len(host_len), .per_len(per_len), .out_of_data(out_of_data),
      .led_green(led_green), .led_red(led_red)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_run, m_err, m_mode, m_len, m_rate, m_chan;
   int m_idx, m_tmode, m_tlen, m_trate;
   int m_sel, m_ood, m_cnt, m_blink;
   bit [1:0] m_full;

   task automatic mreset();
      m_run = 0; m_err = 0; m_mode = 0; m_len = 0; m_rate = 0; m_chan = 0;
      m_idx = 0; m_sel = 0; m_ood = 0; m_cnt = 0; m_blink = 0; m_full = 2'b00;
   endtask

   initial mreset();

   task automatic mword(input int d);
      int ok;
      case (m_idx)
         0: ok = (d <= 7);
         1: ok = (d >= 1 && d <= MAXB);
         2: ok = 1;
         default: ok = (m_tmode <= 1) ? (d == 1) : (d >= 1 && d <= MAXC);
      endcase
      if (!ok) begin
         m_err = 1; m_idx = 0;
      end else if (m_idx == 0) begin
         m_tmode = d; m_idx = 1;
      end else if (m_idx == 1) begin
         m_tlen = d; m_idx = 2;
      end else if (m_idx == 2) begin
         m_trate = d; m_idx = 3;
      end else begin
         m_mode = m_tmode; m_len = m_tlen; m_rate = m_trate; m_chan = d;
         m_run = 1; m_err = 0; m_idx = 0;
      end
   endtask

   function automatic int role(input int md);
      if (md == 0 || md == 2) return 0;   // input
      if (md == 4) return 2;              // echo
      return 1;                           // output
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) mreset();
      else if (soft_rst) mreset();
      else if (m_run == 0) begin
         if (m_cnt == BD - 1) begin m_cnt = 0; m_blink = 1 - m_blink; end
         else m_cnt = m_cnt + 1;
         if (host_wr_vld) mword(int'(host_wr_data));
      end else begin
         bit fe, de;
         bit [1:0] nf;
         m_cnt = 0; m_blink = 0;
         case (role(m_mode))
            0: begin fe = per_blk_done;  de = host_blk_done; end
            2: begin fe = per_blk_done;  de = per_blk_done;  end
            default: begin fe = host_blk_done; de = per_blk_done; end
         endcase
         nf = m_full;
         if (fe) nf[m_sel] = 1'b1;
         if (de) nf[1-m_sel] = 1'b0;
         m_full = nf;
         if (nf[m_sel] && !nf[1-m_sel]) begin m_sel = 1 - m_sel; m_ood = 0; end
         else if (de) m_ood = 1;
      end
   end

   function automatic int exp_len(input bit host_side);
      int fa, da, r;
      if (m_run == 0) return 0;
      fa = !m_full[m_sel];
      da = m_full[1-m_sel];
      r = role(m_mode);
      if (r == 2) return host_side ? 0 : m_len;
      if (r == 0) return (host_side ? da : fa) ? m_len : 0;
      return (host_side ? fa : da) ? m_len : 0;
   endfunction

   // per-cycle comparison
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 run", 32'(run), 32'(m_run));
         chk("R3 cfg_err", 32'(cfg_err), 32'(m_err));
         chk("R2 mode_o", 32'(mode_o), 32'(m_mode));
         chk("R2 blk_len_o", 32'(blk_len_o), 32'(m_len));
         chk("R2 rate_o", 32'(rate_o), 32'(m_rate));
         chk("R2 chan_o", 32'(chan_o), 32'(m_chan));
         chk("R6 buf_sel", 32'(buf_sel), 32'(m_sel));
         chk("R7 host_len", 32'(host_len), 32'(exp_len(1'b1)));
         chk("R7 per_len", 32'(per_len), 32'(exp_len(1'b0)));
         chk("R8 out_of_data", 32'(out_of_data), 32'(m_ood));
         chk("R8 led_red", 32'(led_red), 32'(m_ood));
         chk("R9 led_green", 32'(led_green), 32'((m_run != 0) ? 1 : m_blink));
      end
   end

   // ---------------- stimulus ----------------
   task automatic cyc(input bit vld, input int d, input bit hd, input bit pd, input bit sr);
      host_wr_vld   = vld;
      host_wr_data  = 16'(d);
      host_blk_done = hd;
      per_blk_done  = pd;
      soft_rst      = sr;
      @(negedge clk);
      host_wr_vld = 1'b0; host_blk_done = 1'b0; per_blk_done = 1'b0; soft_rst = 1'b0;
   endtask

   task automatic cfg4(input int md, input int sz, input int rt, input int ch);
      cyc(1, md, 0, 0, 0);
      cyc(1, sz, 0, 0, 0);
      cyc(1, rt, 0, 0, 0);
      cyc(1, ch, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 run", 32'(run), 0);
      chk("R1 outputs", 32'({cfg_err, mode_o, buf_sel, out_of_data, led_green, led_red}), 0);
      chk("R1 lengths", 32'({blk_len_o, host_len, per_len}), 0);
      chk("R1 rate/chan", 32'({rate_o, chan_o}), 0);

      // R9 blink period
      repeat (BD) cyc(0, 0, 0, 0, 0);
      chk("R9 green on after BLINK_DIV", 32'(led_green), 1);
      repeat (BD) cyc(0, 0, 0, 0, 0);
      chk("R9 green off after 2*BLINK_DIV", 32'(led_green), 0);

      // R3 illegal words
      cyc(1, 9, 0, 0, 0);
      chk("R3 mode 9 err", 32'(cfg_err), 1);
      cyc(1, 1, 0, 0, 0); cyc(1, 0, 0, 0, 0);
      chk("R3 size 0 err", 32'({cfg_err, run}), 2);
      cfg4(1, 10, 5, 2);
      chk("R3 fast mode chan 2 err", 32'({cfg_err, run}), 2);
      cyc(1, 1, 0, 0, 0); cyc(1, 4001, 0, 0, 0);
      chk("R3 size 4001 err", 32'({cfg_err, run}), 2);

      // R2 legal output header
      cfg4(1, 256, 1000, 1);
      chk("R2 run set", 32'(run), 1);
      chk("R3 err cleared", 32'(cfg_err), 0);
      chk("R2 committed", 32'({mode_o, blk_len_o, rate_o, chan_o}),
          32'({3'd1, 12'd256, 16'd1000, 5'd1}));
      chk("R5 output mode host armed", 32'({host_len, per_len}), 32'({12'd256, 12'd0}));

      // R4 writes ignored while running
      cyc(1, 3, 0, 0, 0);
      cyc(1, 77, 0, 0, 0);
      chk("R4 mode held", 32'(mode_o), 1);
      chk("R4 len held", 32'(blk_len_o), 256);

      // R6 / R8 ping-pong in output mode
      cyc(0, 0, 1, 0, 0);
      chk("R6 swap after fill", 32'(buf_sel), 1);
      chk("R7 drain armed", 32'(per_len), 256);
      cyc(0, 0, 0, 1, 0);
      chk("R8 starved", 32'({out_of_data, led_red}), 3);
      cyc(0, 0, 1, 0, 0);
      chk("R8 recovered by swap", 32'({out_of_data, buf_sel}), 0);
      cyc(0, 0, 1, 1, 0);
      chk("R6 simultaneous events swap", 32'(buf_sel), 1);
      cyc(0, 0, 1, 0, 0);
      chk("R7 both full host idle", 32'({host_len, per_len}), 32'({12'd0, 12'd256}));
      cyc(0, 0, 1, 0, 0);
      chk("R6 fill on full ignored", 32'({buf_sel, host_len}), 32'({1'b1, 12'd0}));
      cyc(0, 0, 0, 1, 0);
      chk("R6 swap after drain", 32'({buf_sel, host_len}), 32'({1'b0, 12'd256}));

      // R10 soft reset mid-transfer
      cyc(0, 0, 1, 0, 0);
      cyc(0, 0, 0, 0, 1);
      chk("R10 cleared", 32'({run, buf_sel, out_of_data, led_green, mode_o}), 0);
      chk("R10 lengths", 32'({blk_len_o, host_len, per_len}), 0);

      // R5 input mode, max size and channels
      cfg4(2, 4000, 30, 16);
      chk("R5 input mode per armed", 32'({host_len, per_len}), 32'({12'd0, 12'd4000}));
      cyc(0, 0, 1, 0, 0);
      chk("R8 host drain starved", 32'(out_of_data), 1);
      cyc(0, 0, 0, 1, 0);
      chk("R5 per fill swaps", 32'({buf_sel, out_of_data}), 2);
      chk("R5 host drain armed", 32'(host_len), 4000);

      // R11 echo
      cyc(0, 0, 0, 0, 1);
      cfg4(4, 1, 2, 3);
      chk("R11 echo lens", 32'({host_len, per_len}), 32'({12'd0, 12'd1}));
      cyc(0, 0, 0, 1, 0);
      chk("R11 swap 1", 32'(buf_sel), 1);
      cyc(0, 0, 0, 1, 0);
      chk("R11 swap 2", 32'({buf_sel, out_of_data}), 0);
      cyc(0, 0, 1, 0, 0);
      chk("R11 host event ignored", 32'({buf_sel, out_of_data, host_len}), 0);

      // R3 upper boundaries accepted
      cyc(0, 0, 0, 0, 1);
      cfg4(7, 4000, 65535, 16);
      chk("R3 mode 7 chan 16 ok", 32'({run, cfg_err}), 2);
      chk("R2 rate max", 32'(rate_o), 65535);

      repeat (3) cyc(0, 0, 0, 1, 0);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule